// File: doc/BRIEF.md
# Double-Buffered Converter Register Front-End

This block is the digital side of a parallel-input voltage converter. A host reaches it through an active-low select, a read/write line and a bidirectional data bus. Through these it can write a straight-binary code into a staging register or read that code back. A separate load strobe moves the staged code into the converter register. That register is the only value presented to the analog side. Because of this split, a new code can be prepared at any time without disturbing the output until the host chooses to commit it.

A reset strobe clears both registers. A reset-select input chooses the target: zero-scale (all zeros) or mid-scale (only the MSB set). All strobes and control lines are asynchronous to the system clock. They are brought in through multi-flop synchronizers, and the load and reset strobes act only on their rising edges.

Top module: `dbuf_dac_front`

## Requirements
- R1: With `sel_n` low and `rd_wr` low, the word on `data_io` is written into the input register. `data_io[i]` maps to code bit i, and bit DATA_W-1 is the MSB.
- R2: With `sel_n` low and `rd_wr` high, the block asserts `bus_oe` and drives the input register onto `data_io`.
- R3: With `sel_n` high, `bus_oe` is low, the bus is released, and bus activity leaves the input register unchanged.
- R4: A rising edge on `load` copies the input register into the converter register shown on `code_o`.
- R5: Loading acts on the edge only. A write made while `load` stays high, or while it stays low, does not change `code_o` until the next rising edge of `load`.
- R6: A rising edge on `clr` with `clr_mid` high sets both registers to mid-scale. Only the MSB is set, which is 8000h at 16 bits.
- R7: A rising edge on `clr` with `clr_mid` low sets both registers to 0000h.
- R8: After the system reset `rst_n`, both registers read 0000h and `bus_oe` is low.
- R9: If the load edge and the clear edge are seen in the same cycle, the clear wins and the converter register takes the clear code.
- R10: The value of `clr_mid` at the clear edge decides the code. Changing `clr_mid` afterwards, without a new edge, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| sel_n | input | 1 | Active-low chip select |
| rd_wr | input | 1 | 1 = read back, 0 = write |
| data_io | inout | DATA_W | Bidirectional data bus |
| load | input | 1 | Load strobe, rising-edge active |
| clr | input | 1 | Clear strobe, rising-edge active |
| clr_mid | input | 1 | Clear target: 1 = mid-scale, 0 = zero |
| bus_oe | output | 1 | High while the block drives the bus |
| code_o | output | DATA_W | Converter register code |

## Verification
The bench builds the block with its defaults: a 16-bit word, two synchronizer stages, and the bus data passed through the synchronizer. With these settings the mid-scale code is exactly 8000h, and the all-ones and MSB-only patterns test the bit ordering end to end. Because bus data and controls share one synchronizer depth, the bench can check that a written word lands intact rather than skewed by one cycle. The same clock edge then carries matched load and clear pulses, which exposes the clear-over-load priority.

// File: rtl/dbf_pkg.sv
package dbf_pkg;

   typedef enum logic [1:0] {
      BUS_IDLE  = 2'd0,
      BUS_WRITE = 2'd1,
      BUS_READ  = 2'd2
   } bus_op_e;

   // Control bundle bit positions inside the synchronizer vector
   localparam int CTL_SEL_N = 4;
   localparam int CTL_RDWR  = 3;
   localparam int CTL_LOAD  = 2;
   localparam int CTL_CLR   = 1;
   localparam int CTL_MID   = 0;
   localparam int CTL_W     = 5;

   function automatic bus_op_e decode_bus(input logic sel_n, input logic rd_wr);
      if (sel_n)      return BUS_IDLE;
      else if (rd_wr) return BUS_READ;
      else            return BUS_WRITE;
   endfunction

endpackage

// File: rtl/dbf_sync.sv
module dbf_sync #(
   parameter int              W       = 1,
   parameter int              STAGES  = 2,
   parameter logic [W-1:0]    RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_depth
      $error("dbf_sync: STAGES must be at least 1");
   end

   logic [W-1:0] st [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= RST_VAL;
            else        st[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[i] <= RST_VAL;
            else        st[i] <= st[i-1];
         end
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/dbf_edge.sv
module dbf_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl;
   end

   assign rise = lvl & ~prev_q;
endmodule

// File: rtl/dbf_regs.sv
module dbf_regs #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              load_pulse,
   input  logic              clr_pulse,
   input  logic              clr_mid,
   output logic [DATA_W-1:0] in_q,
   output logic [DATA_W-1:0] dac_q
);
   localparam logic [DATA_W-1:0] ZERO_CODE = '0;
   localparam logic [DATA_W-1:0] MID_CODE  = {1'b1, {(DATA_W-1){1'b0}}};

   logic [DATA_W-1:0] clr_code;
   assign clr_code = clr_mid ? MID_CODE : ZERO_CODE;

   // Staging register: clear outranks a write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         in_q <= ZERO_CODE;
      else if (clr_pulse) in_q <= clr_code;
      else if (wr_en)     in_q <= wr_data;
   end

   // Converter register: clear outranks load
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          dac_q <= ZERO_CODE;
      else if (clr_pulse)  dac_q <= clr_code;
      else if (load_pulse) dac_q <= in_q;
   end

   a_r4_load_copies: assert property (@(posedge clk) disable iff (!rst_n)
      (load_pulse && !clr_pulse) |=> (dac_q == $past(in_q)));

   a_r5_dac_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_pulse && !clr_pulse) |=> $stable(dac_q));

   a_r3_input_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !clr_pulse) |=> $stable(in_q));

   a_r6_clear_mid: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse && clr_mid) |=> (in_q == MID_CODE && dac_q == MID_CODE));

   a_r7_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse && !clr_mid) |=> (in_q == ZERO_CODE && dac_q == ZERO_CODE));

   a_r9_clear_beats_load: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pulse && load_pulse) |=> (dac_q == in_q));
endmodule

// File: rtl/dbuf_dac_front.sv
module dbuf_dac_front #(
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit SYNC_DATA   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              rd_wr,
   inout  wire  [DATA_W-1:0] data_io,
   input  logic              load,
   input  logic              clr,
   input  logic              clr_mid,
   output logic              bus_oe,
   output logic [DATA_W-1:0] code_o
);
   import dbf_pkg::*;

   if (DATA_W < 2) begin : g_bad_width
      $error("dbuf_dac_front: DATA_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("dbuf_dac_front: SYNC_STAGES must be at least 2");
   end

   localparam logic [CTL_W-1:0] CTL_RST = 5'b10000; // select idles inactive

   logic [CTL_W-1:0]  ctl_raw, ctl_q;
   logic [DATA_W-1:0] bus_q, in_q, dac_q;
   logic              load_rise, clr_rise;
   bus_op_e           op;

   assign ctl_raw = {sel_n, rd_wr, load, clr, clr_mid};

   dbf_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_q)
   );

   // Bus data either shares the control latency or is taken directly
   if (SYNC_DATA) begin : g_data_sync
      dbf_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_data_sync (
         .clk(clk), .rst_n(rst_n), .d(data_io), .q(bus_q)
      );
   end else begin : g_data_direct
      assign bus_q = data_io;
   end

   dbf_edge u_load_edge (
      .clk(clk), .rst_n(rst_n), .lvl(ctl_q[CTL_LOAD]), .rise(load_rise)
   );

   dbf_edge u_clr_edge (
      .clk(clk), .rst_n(rst_n), .lvl(ctl_q[CTL_CLR]), .rise(clr_rise)
   );

   assign op = decode_bus(ctl_q[CTL_SEL_N], ctl_q[CTL_RDWR]);

   dbf_regs #(.DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (op == BUS_WRITE),
      .wr_data    (bus_q),
      .load_pulse (load_rise),
      .clr_pulse  (clr_rise),
      .clr_mid    (ctl_q[CTL_MID]),
      .in_q       (in_q),
      .dac_q      (dac_q)
   );

   assign bus_oe  = (op == BUS_READ);
   assign data_io = bus_oe ? in_q : {DATA_W{1'bz}};
   assign code_o  = dac_q;

   a_r3_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_q[CTL_SEL_N] |-> !bus_oe);

   a_r2_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe |-> (ctl_q[CTL_RDWR] && !ctl_q[CTL_SEL_N]));
endmodule

// File: tb/tb_dbuf_dac_front.sv
module tb_dbuf_dac_front;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sel_n = 1'b1;
   logic         rd_wr = 1'b1;
   logic         load = 1'b0;
   logic         clr = 1'b0;
   logic         clr_mid = 1'b0;
   logic         tb_en = 1'b0;
   logic [W-1:0] tb_drv = '0;
   wire  [W-1:0] data_io;
   logic         bus_oe;
   logic [W-1:0] code_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   assign data_io = tb_en ? tb_drv : {W{1'bz}};

   dbuf_dac_front dut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr(rd_wr),
      .data_io(data_io), .load(load), .clr(clr), .clr_mid(clr_mid),
      .bus_oe(bus_oe), .code_o(code_o)
   );

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (5) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_write(input logic [W-1:0] v);
      tb_drv = v; tb_en = 1'b1; rd_wr = 1'b0; sel_n = 1'b0;
      settle();
      sel_n = 1'b1;
      settle();
      tb_en = 1'b0; rd_wr = 1'b1;
   endtask

   task automatic t_read(input string req, input logic [W-1:0] exp);
      tb_en = 1'b0; rd_wr = 1'b1; sel_n = 1'b0;
      settle();
      check(req, {{(W-1){1'b0}}, bus_oe}, 1);
      check(req, data_io, exp);
      sel_n = 1'b1;
      settle();
      check("R3 bus released", {{(W-1){1'b0}}, bus_oe}, 0);
   endtask

   task automatic t_load();
      load = 1'b1; settle();
      load = 1'b0; settle();
   endtask

   task automatic t_clear(input logic mid);
      clr_mid = mid; settle();
      clr = 1'b1; settle();
      clr = 1'b0; settle();
   endtask

   task automatic t_power_up();
      check("R8 code after reset", code_o, 16'h0000);
      check("R8 oe after reset", {{(W-1){1'b0}}, bus_oe}, 0);
      t_read("R8 input after reset", 16'h0000);
   endtask

   task automatic t_write_read();
      t_write(16'hA5C3); t_read("R1 R2 pattern A5C3", 16'hA5C3);
      t_write(16'hFFFF); t_read("R1 R2 all ones", 16'hFFFF);
      t_write(16'h8000); t_read("R1 MSB only", 16'h8000);
      check("R5 write without load leaves code", code_o, 16'h0000);
   endtask

   task automatic t_deselect_hold();
      t_write(16'h1357);
      tb_drv = 16'hBEEF; tb_en = 1'b1; rd_wr = 1'b0; sel_n = 1'b1;
      settle();
      tb_en = 1'b0; rd_wr = 1'b1;
      t_read("R3 deselected bus ignored", 16'h1357);
   endtask

   task automatic t_load_edge();
      t_write(16'h0F0F);
      t_load();
      check("R4 load copies", code_o, 16'h0F0F);
      load = 1'b1; settle();
      t_write(16'h7001);
      check("R5 held level no reload", code_o, 16'h0F0F);
      load = 1'b0; settle();
      check("R5 falling edge no load", code_o, 16'h0F0F);
      t_load();
      check("R4 second edge loads", code_o, 16'h7001);
   endtask

   task automatic t_clears();
      t_write(16'h4444); t_load(); t_write(16'h2222);
      t_clear(1'b1);
      check("R6 mid clear code", code_o, 16'h8000);
      t_read("R6 mid clear input", 16'h8000);
      t_write(16'h3333); t_load();
      t_clear(1'b0);
      check("R7 zero clear code", code_o, 16'h0000);
      t_read("R7 zero clear input", 16'h0000);
   endtask

   task automatic t_clear_select_late();
      clr_mid = 1'b1; settle();
      clr = 1'b1; settle();
      clr_mid = 1'b0; settle();
      check("R10 select after edge ignored", code_o, 16'h8000);
      clr = 1'b0; settle();
      check("R10 no edge no change", code_o, 16'h8000);
      t_read("R10 input kept mid", 16'h8000);
   endtask

   task automatic t_clear_vs_load();
      t_write(16'h5555); t_load();
      t_write(16'h1234);
      clr_mid = 1'b0; settle();
      load = 1'b1; clr = 1'b1; settle();
      load = 1'b0; clr = 1'b0; settle();
      check("R9 clear beats load", code_o, 16'h0000);
      t_read("R9 input cleared", 16'h0000);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      settle();
      t_power_up();
      t_write_read();
      t_deselect_hold();
      t_load_edge();
      t_clears();
      t_clear_select_late();
      t_clear_vs_load();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule